// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is a general-purpose up-counter with three compare channels, reached through a word-addressed register port with separate read and write strobes. A three-bit source field picks one of three tick inputs. Each tick is a single-cycle enable pulse in the system clock domain. A 12-bit prescaler divides the chosen tick, and every divided tick advances the counter by one. Each compare channel sets its own status flag when the counter lands on its value. A level interrupt combines the status flags, a six-bit interrupt mask and the global enable.

In free-running mode the counter wraps from all ones to zero and records a rollover. In restart mode, compare channel 1 also sets the period: the count returns to zero on the step after it matches channel 1, and any write to channel 1 restarts the count at once. Enabling the timer either resumes from the held count or starts again from zero, depending on an enable-mode bit. A self-clearing software-reset bit sets most of the block back to its reset values but leaves part of the control word unchanged. The two capture registers read as zero, and no capture logic is behind them.

Top module: `cmp_timer`

## Requirements
- R1: Word offsets decode as 0 control, 1 prescaler, 2 status, 3 interrupt mask, 4/5/6 compare 1/2/3, 7/8 capture (always read 0, writes ignored), 9 counter (read only). Every other offset reads 0 and ignores writes. Compare registers keep the low CNT_W bits of a write.
- R2: Control bits [8:6] select the tick source: 001 is tick_main, 010 is tick_fast, 100 is tick_slow. Every other code selects no tick, and the counter then holds.
- R3: The prescaler stores the low 12 bits of a write. The counter advances once every (prescaler + 1) selected ticks while control bit 0 (enable) is set.
- R4: With control bit 9 (free-run) clear, a step taken while the counter equals compare 1 takes the counter to zero.
- R5: On a step from all ones, the counter goes to zero and status bit 5 (rollover) is set.
- R6: While free-run is clear, any write to compare 1 resets the counter to zero in the same clock.
- R7: Status bits 0, 1 and 2 are set when a step brings the counter to compare 1, 2 or 3. This happens whatever the interrupt mask holds.
- R8: Writing the status register clears each flag whose written bit is 1 and leaves the others alone. A flag set in the same cycle as its clear stays set.
- R9: The interrupt mask stores the low 6 bits of a write. irq is high only while enable is set and status AND mask is nonzero.
- R10: A control write always stores bits 2, 4 and 10 to 14 as zero.
- R11: A control write that takes enable from 0 to 1 with bit 1 (enable-mode) set restarts the counter at zero. With enable-mode clear, the counter resumes from its held value. While enable is clear, the counter holds.
- R12: A control write with bit 15 set clears enable, enable-mode and mode bits 3, 5, 16 and 17, and keeps the other written control bits. It zeroes status, prescaler, mask and counter, and sets all compares to all ones. Bit 15 reads back as 0 from the following cycle.
- R13: bus_rdata takes the addressed register's value at the clock edge where bus_rd is high, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| tick_main | input | 1 | Peripheral tick pulse (source 001) |
| tick_fast | input | 1 | High-frequency tick pulse (source 010) |
| tick_slow | input | 1 | Low-frequency tick pulse (source 100) |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, counter steps and status updates all take effect at the clock edge where the strobe or tick is high. irq follows those registers with no further delay. Read data appears one edge after bus_rd. The bench drives every strobe and tick for exactly one cycle between falling edges, then issues a read and samples bus_rdata at the next falling edge, so every value it checks has had exactly one register stage of latency. The same-cycle cases (a flag set while it is being cleared, and a compare-1 write that overrides a step) are driven in a single shared cycle.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int DW     = 32;
  localparam int FLAG_W = 6;
  localparam int N_CMP  = 3;

  // register word offsets
  localparam int REG_CTRL = 0;
  localparam int REG_PRE  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_MASK = 3;
  localparam int REG_CMP0 = 4;
  localparam int REG_CNT  = 9;

  // control bit positions
  localparam int C_EN     = 0;
  localparam int C_ENMODE = 1;
  localparam int C_DBG    = 3;
  localparam int C_WAIT   = 5;
  localparam int C_SRC    = 6;
  localparam int C_FREE   = 9;
  localparam int C_SWR    = 15;
  localparam int C_DOZE   = 16;
  localparam int C_STOP   = 17;

  localparam logic [DW-1:0] CTRL_ZERO_MASK = 32'h0000_7C14;
  localparam logic [DW-1:0] SWR_CLR_MASK   =
    (32'd1 << C_EN) | (32'd1 << C_ENMODE) | (32'd1 << C_DBG) |
    (32'd1 << C_WAIT) | (32'd1 << C_DOZE) | (32'd1 << C_STOP);

  localparam logic [2:0] SRC_MAIN = 3'b001;
  localparam logic [2:0] SRC_FAST = 3'b010;
  localparam logic [2:0] SRC_SLOW = 3'b100;

  localparam int ST_ROLL = 5;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
  import cmp_timer_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       src,
  input  logic             tick_main,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [PRE_W-1:0] div,
  input  logic             clear,
  output logic             step
);
  logic             sel_tick;
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    case (src)
      SRC_MAIN: sel_tick = tick_main;
      SRC_FAST: sel_tick = tick_fast;
      SRC_SLOW: sel_tick = tick_slow;
      default:  sel_tick = 1'b0;
    endcase
  end

  // >= keeps a lowered divider from running the phase counter around
  assign step = run && sel_tick && (pre_q >= div);

  always_comb begin
    pre_d = pre_q;
    if (clear)                pre_d = '0;
    else if (step)            pre_d = '0;
    else if (run && sel_tick) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  logic                        restart,
  input  logic                        free_run,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]            cnt,
  output logic [N_CMP-1:0]            hit,
  output logic                        wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;

  assign adv = step && !restart;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (step) begin
      if ((!free_run && cnt_q == cmp[0]) || cnt_q == CNT_MAX) cnt_d = '0;
      else                                                    cnt_d = cnt_q + 1'b1;
    end
  end

  assign wrap = adv && (cnt_q == CNT_MAX);

  for (genvar i = 0; i < N_CMP; i++) begin : g_hit
    assign hit[i] = adv && (cnt_d == cmp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick_main,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  logic [DW-1:0]                 ctrl_q, ctrl_d, wval;
  logic [PRE_W-1:0]              pre_q, pre_d;
  logic [FLAG_W-1:0]             sr_q, sr_d, sr_set, sr_clr;
  logic [FLAG_W-1:0]             mask_q, mask_d;
  logic [N_CMP-1:0][CNT_W-1:0]   cmp_q, cmp_d;
  logic [DW-1:0]                 rdata_q, rdata_d;
  logic [CNT_W-1:0]              cnt_w;
  logic [N_CMP-1:0]              hit_w, wr_cmp;
  logic                          wrap_w, step_w;
  logic                          wr_ctrl, wr_pre, wr_stat, wr_mask;
  logic                          swr_now, en_restart, cmp0_restart, cnt_restart;

  assign wr_ctrl = bus_wr && bus_addr == ADDR_W'(REG_CTRL);
  assign wr_pre  = bus_wr && bus_addr == ADDR_W'(REG_PRE);
  assign wr_stat = bus_wr && bus_addr == ADDR_W'(REG_STAT);
  assign wr_mask = bus_wr && bus_addr == ADDR_W'(REG_MASK);
  for (genvar i = 0; i < N_CMP; i++) begin : g_wdec
    assign wr_cmp[i] = bus_wr && bus_addr == ADDR_W'(REG_CMP0 + i);
  end

  assign wval         = bus_wdata & ~CTRL_ZERO_MASK;
  assign swr_now      = wr_ctrl && wval[C_SWR];
  assign en_restart   = wr_ctrl && !swr_now && !ctrl_q[C_EN] &&
                        wval[C_EN] && wval[C_ENMODE];
  assign cmp0_restart = wr_cmp[0] && !ctrl_q[C_FREE];
  assign cnt_restart  = swr_now || en_restart || cmp0_restart;

  cmp_timer_tick #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q[C_EN]),
    .src       (ctrl_q[C_SRC +: 3]),
    .tick_main (tick_main),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .div       (pre_q),
    .clear     (cnt_restart),
    .step      (step_w)
  );

  cmp_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step_w),
    .restart  (cnt_restart),
    .free_run (ctrl_q[C_FREE]),
    .cmp      (cmp_q),
    .cnt      (cnt_w),
    .hit      (hit_w),
    .wrap     (wrap_w)
  );

  // next-state for the register file
  always_comb begin
    ctrl_d = ctrl_q;
    if (swr_now)              ctrl_d = wval & ~SWR_CLR_MASK;
    else if (wr_ctrl)         ctrl_d = wval;
    else if (ctrl_q[C_SWR])   ctrl_d[C_SWR] = 1'b0;

    pre_d = pre_q;
    if (swr_now)     pre_d = '0;
    else if (wr_pre) pre_d = bus_wdata[PRE_W-1:0];

    mask_d = mask_q;
    if (swr_now)      mask_d = '0;
    else if (wr_mask) mask_d = bus_wdata[FLAG_W-1:0];

    sr_set = '0;
    sr_set[N_CMP-1:0] = hit_w;
    sr_set[ST_ROLL]   = wrap_w;
    sr_clr = wr_stat ? bus_wdata[FLAG_W-1:0] : '0;
    sr_d   = swr_now ? '0 : ((sr_q & ~sr_clr) | sr_set);

    for (int i = 0; i < N_CMP; i++) begin
      cmp_d[i] = cmp_q[i];
      if (swr_now)        cmp_d[i] = '1;
      else if (wr_cmp[i]) cmp_d[i] = bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      if (bus_addr == ADDR_W'(REG_CTRL)) rdata_d = ctrl_q;
      if (bus_addr == ADDR_W'(REG_PRE))  rdata_d = DW'(pre_q);
      if (bus_addr == ADDR_W'(REG_STAT)) rdata_d = DW'(sr_q);
      if (bus_addr == ADDR_W'(REG_MASK)) rdata_d = DW'(mask_q);
      for (int i = 0; i < N_CMP; i++)
        if (bus_addr == ADDR_W'(REG_CMP0 + i)) rdata_d = DW'(cmp_q[i]);
      if (bus_addr == ADDR_W'(REG_CNT))  rdata_d = DW'(cnt_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pre_q   <= '0;
      sr_q    <= '0;
      mask_q  <= '0;
      cmp_q   <= '1;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pre_q   <= pre_d;
      sr_q    <= sr_d;
      mask_q  <= mask_d;
      cmp_q   <= cmp_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = ctrl_q[C_EN] && |(sr_q & mask_q);
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     ctrl,
  input logic [FLAG_W-1:0] sr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp1,
  input logic              irq
);
  logic wr_c, wr_swr;
  assign wr_c   = bus_wr && bus_addr == ADDR_W'(REG_CTRL);
  assign wr_swr = wr_c && bus_wdata[C_SWR];

  // R9: no interrupt while the timer is disabled
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[C_EN] |-> !irq);

  // R12: software reset state is visible one cycle later
  a_r12_swr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_swr |=> (sr == '0 && !ctrl[C_EN] && cnt == '0 && cmp1 == '1));

  // R12: reset bit clears itself
  a_r12_swr_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[C_SWR] && !wr_swr) |=> !ctrl[C_SWR]);

  // R6: compare-1 write restarts the count in restart mode
  a_r6_cmp1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(REG_CMP0) && !ctrl[C_FREE]) |=> cnt == '0);

  // R11: enabling with enable-mode starts from zero
  a_r11_enmode_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !ctrl[C_EN] && bus_wdata[C_EN] && bus_wdata[C_ENMODE] &&
     !bus_wdata[C_SWR]) |=> cnt == '0);

  // R11: counter holds while disabled and untouched
  a_r11_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[C_EN] && !bus_wr) |=> $stable(cnt));

  // R4: the counter only steps by one or returns to zero
  a_r4_step_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctrl      (ctrl_q),
  .sr        (sr_q),
  .cnt       (cnt_w),
  .cmp1      (cmp_q[0]),
  .irq       (irq)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int CW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cmp_timer #(.CNT_W(CW), .PRE_W(12), .ADDR_W(AW)) u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_main(tick_main), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .irq(irq)
  );

  // {offset, write data, expected read-back}
  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {4'h0, 32'h0000_7FFE, 32'h0000_03EA},
    {4'h0, 32'h0000_0000, 32'h0000_0000},
    {4'h1, 32'hFFFF_FABC, 32'h0000_0ABC},
    {4'h1, 32'h0000_0000, 32'h0000_0000},
    {4'h3, 32'hFFFF_FFFF, 32'h0000_003F},
    {4'h3, 32'h0000_0000, 32'h0000_0000},
    {4'h4, 32'h0000_0177, 32'h0000_0077},
    {4'h5, 32'h0000_1234, 32'h0000_0034},
    {4'h6, 32'h0000_00A5, 32'h0000_00A5},
    {4'h7, 32'h0000_0055, 32'h0000_0000},
    {4'h8, 32'h0000_00AA, 32'h0000_0000},
    {4'h9, 32'h0000_0033, 32'h0000_0000},
    {4'hB, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'hF, 32'h1234_5678, 32'h0000_0000},
    {4'h2, 32'h0000_003F, 32'h0000_0000},
    {4'h0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {tick_slow, tick_fast, tick_main} = which;
      @(negedge clk);
      {tick_slow, tick_fast, tick_main} = 3'b000;
    end
  endtask

  task automatic rchk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R12 values after hardware reset)
    rchk("R12 reset ctrl", 4'h0, 32'h0);
    rchk("R12 reset cmp1", 4'h4, 32'hFF);
    rchk("R12 reset cnt", 4'h9, 32'h0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    // register map walk: R1, R3, R9, R10, R13
    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      wr(VEC[k][67:64], VEC[k][63:32]);
      rd(VEC[k][67:64], v);
      chk($sformatf("R1/R10/R13 vector %0d", k), v, VEC[k][31:0]);
    end

    // R2 / R3: source select and prescaler, free-run
    wr(4'h0, 32'h241);
    pulse(3'b001, 5);
    rchk("R2 main tick counts", 4'h9, 32'd5);
    pulse(3'b010, 3);
    rchk("R2 unselected tick ignored", 4'h9, 32'd5);
    wr(4'h0, 32'h301);
    pulse(3'b100, 2);
    rchk("R2 slow tick counts", 4'h9, 32'd7);
    wr(4'h0, 32'h2C1);
    pulse(3'b111, 3);
    rchk("R2 invalid source holds", 4'h9, 32'd7);
    wr(4'h0, 32'h241);
    wr(4'h1, 32'd2);
    pulse(3'b001, 6);
    rchk("R3 divide by three", 4'h9, 32'd9);
    wr(4'h1, 32'd0);

    // R5 / R7: free-run wrap and compare flags with mask clear
    wr(4'h2, 32'h3F);
    pulse(3'b001, 246);
    rchk("R7 count at max", 4'h9, 32'hFF);
    rchk("R7 compare flags set unmasked", 4'h2, 32'h07);
    pulse(3'b001, 1);
    rchk("R5 wrap to zero", 4'h9, 32'h0);
    rchk("R5 rollover flag", 4'h2, 32'h27);

    // R8: write-one-to-clear and set-wins
    wr(4'h2, 32'h05);
    rchk("R8 partial clear", 4'h2, 32'h22);
    pulse(3'b001, 8'h33);
    @(negedge clk);
    tick_main = 1'b1; bus_addr = 4'h2; bus_wdata = 32'h02; bus_wr = 1'b1;
    @(negedge clk);
    tick_main = 1'b0; bus_wr = 1'b0;
    rchk("R8 set wins over clear", 4'h2, 32'h22);
    wr(4'h2, 32'h02);
    rchk("R8 clear after", 4'h2, 32'h20);

    // R9 / R11: interrupt gating and resume
    wr(4'h3, 32'h20);
    @(negedge clk);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    wr(4'h0, 32'h240);
    chk("R9 irq gated by enable", {31'd0, irq}, 32'd0);
    pulse(3'b001, 2);
    rchk("R11 hold while disabled", 4'h9, 32'h34);
    wr(4'h0, 32'h241);
    chk("R9 irq back", {31'd0, irq}, 32'd1);
    pulse(3'b001, 1);
    rchk("R11 resume from held value", 4'h9, 32'h35);
    wr(4'h2, 32'h3F);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);
    wr(4'h3, 32'h0);

    // R11: enable-mode restart
    wr(4'h0, 32'h240);
    wr(4'h0, 32'h243);
    rchk("R11 enable-mode restart", 4'h9, 32'h0);
    pulse(3'b001, 2);
    rchk("R11 counts after restart", 4'h9, 32'd2);

    // R4 / R6: restart mode
    wr(4'h0, 32'h041);
    wr(4'h2, 32'h3F);
    wr(4'h4, 32'h04);
    rchk("R6 cmp1 write restarts", 4'h9, 32'h0);
    pulse(3'b001, 4);
    rchk("R4 reaches compare 1", 4'h9, 32'd4);
    rchk("R7 compare 1 flag", 4'h2, 32'h01);
    pulse(3'b001, 1);
    rchk("R4 returns to zero", 4'h9, 32'h0);
    pulse(3'b001, 2);
    wr(4'h4, 32'h04);
    rchk("R6 restart mid count", 4'h9, 32'h0);

    // R12: software reset
    wr(4'h1, 32'd5);
    wr(4'h3, 32'h3F);
    wr(4'h5, 32'h10);
    wr(4'h0, 32'h0010_8243);
    rchk("R12 control kept bits", 4'h0, 32'h0010_0240);
    rchk("R12 prescaler zero", 4'h1, 32'h0);
    rchk("R12 mask zero", 4'h3, 32'h0);
    rchk("R12 status zero", 4'h2, 32'h0);
    rchk("R12 cmp2 all ones", 4'h5, 32'hFF);
    rchk("R12 cmp3 all ones", 4'h6, 32'hFF);
    pulse(3'b001, 3);
    rchk("R12 counter zero and stopped", 4'h9, 32'h0);
    chk("R12 irq low", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule